// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

The block collects up to eight interrupt requests, ranks them by a fixed priority and raises a single interrupt line towards a processor. The processor reaches it through a byte-wide bus with two registers, a command register and a data register. Software first loads the block with a short sequence of configuration words. These words set the vector base, the cascade word and the end-of-interrupt mode. After that, software uses command bytes to retire serviced levels and to choose which internal register a command read returns. Data writes load the mask.

When the processor sees the interrupt line, it pulses an acknowledge request. One cycle later the block answers with an acknowledge pulse and a vector byte. The level that wins moves from pending to in service, and it stays in service until software retires it, unless automatic retirement was chosen at configuration. When nothing qualifies at the moment of acknowledge, the block hands back the vector of the lowest level and records nothing.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the pending and in-service registers are 0, command reads return the pending register, and `int_out` stays low until a configuration sequence has completed.
- R2: A command write with bit 4 set starts configuration and returns command readback to the pending register. It clears the pending and in-service registers, turns automatic retirement off and leaves the mask unchanged. The data writes that follow are taken in this order: the base word; the cascade word, skipped when bit 1 of the start word is 1; and the mode word, skipped when bit 0 of the start word is 0. The block is then configured.
- R3: A data write outside configuration loads the mask, where bit n = 1 blocks input n. A data read (`bus_sel` = 1) returns the mask.
- R4: Pending bit n is set on a rising edge of `irq_in[n]` whatever the mask holds. It is cleared when `irq_in[n]` is low or when the level is acknowledged.
- R5: With level 0 as the highest priority, `int_out` is high when some unmasked pending bit n has an index lower than every set in-service bit.
- R6: The cycle after `inta_req`, `inta_ack` pulses for one cycle with `vec_out` = {base word bits 7:3, n}, where n is the winning level. That pending bit clears and, unless automatic retirement is on, in-service bit n sets. `vec_out` is 0 whenever `inta_ack` is low.
- R7: When bit 1 of the mode word is 1 (automatic retirement), an acknowledge leaves the in-service register unchanged.
- R8: If no level qualifies under R5 when `inta_req` arrives, the vector carries level 7 and the in-service register is left unchanged. This happens even when the request vanished before acknowledge or is masked.
- R9: Command byte 0x60+n (n = 0..7) clears in-service bit n only.
- R10: Command byte 0x20 clears the highest-priority set in-service bit.
- R11: Command byte 0x0B makes later command reads (`bus_sel` = 0) return the in-service register, and 0x0A makes them return the pending register. The choice holds until it is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the selected register |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt line to the processor |
| inta_req | input | 1 | Acknowledge request pulse |
| inta_ack | output | 1 | Acknowledge answer pulse |
| vec_out | output | 8 | Vector byte, valid while `inta_ack` is high |

## Verification
A wrong in-service register shows up quickly. The cycle after the bad update, `int_out` is gated wrongly against lower levels. The next acknowledge returns a wrong or spurious vector, and an ISR readback after an end-of-interrupt command shows it too. A wrong configuration step shifts every later data write by one slot, so the mask readback or the next vector base is wrong from the first acknowledge on. Pending-register faults appear in the same cycle as a pending readback, and the next `int_out` sample shows them as well.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);

  typedef enum logic [1:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE
  } cfg_state_e;

  // Index of the lowest set bit, or LINES when none is set.
  function automatic logic [LW:0] first_set(input logic [LINES-1:0] v);
    logic [LW:0] r;
    r = LW'(0) + (LW+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) r = (LW+1)'(i);
    end
    return r;
  endfunction

  // Lines whose index is strictly below idx.
  function automatic logic [LINES-1:0] below_mask(input logic [LW:0] idx);
    logic [LINES-1:0] m;
    for (int i = 0; i < LINES; i++) begin
      m[i] = (i < int'(idx));
    end
    return m;
  endfunction

  function automatic logic [LINES-1:0] onehot(input logic [LW-1:0] idx);
    logic [LINES-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] make_vector(input logic [7-LW:0] base,
                                             input logic [LW-1:0] lvl);
    return {base, lvl};
  endfunction

endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] imr,
  output logic [7-LW:0] vec_base,
  output logic          aeoi,
  output logic          ready,
  output logic          rd_isr,
  output logic          init_start,
  output logic          eoi_spec,
  output logic [LW-1:0] eoi_idx,
  output logic          eoi_any
);

  cfg_state_e state_q;
  logic       need_casc_q, need_mode_q;
  logic       cmd_wr, dat_wr, op_sel, op_eoi;

  assign cmd_wr     = wr && !sel;
  assign dat_wr     = wr && sel;
  assign init_start = cmd_wr && wdata[4];
  assign op_sel     = cmd_wr && !wdata[4] && wdata[3];
  assign op_eoi     = cmd_wr && !wdata[4] && !wdata[3];
  assign eoi_spec   = op_eoi && (wdata[7:5] == 3'b011);
  assign eoi_any    = op_eoi && (wdata[7:5] == 3'b001);
  assign eoi_idx    = wdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= CFG_IDLE;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      imr         <= '1;
      vec_base    <= '0;
      aeoi        <= 1'b0;
      ready       <= 1'b0;
      rd_isr      <= 1'b0;
    end else if (init_start) begin
      state_q     <= CFG_BASE;
      need_casc_q <= !wdata[1];
      need_mode_q <= wdata[0];
      aeoi        <= 1'b0;
      ready       <= 1'b0;
      rd_isr      <= 1'b0;
    end else begin
      if (op_sel && wdata[1]) rd_isr <= wdata[0];
      if (dat_wr) begin
        unique case (state_q)
          CFG_BASE: begin
            vec_base <= wdata[DW-1:LW];
            if (need_casc_q)      state_q <= CFG_CASC;
            else if (need_mode_q) state_q <= CFG_MODE;
            else begin
              state_q <= CFG_IDLE;
              ready   <= 1'b1;
            end
          end
          CFG_CASC: begin
            if (need_mode_q) state_q <= CFG_MODE;
            else begin
              state_q <= CFG_IDLE;
              ready   <= 1'b1;
            end
          end
          CFG_MODE: begin
            aeoi    <= wdata[1];
            state_q <= CFG_IDLE;
            ready   <= 1'b1;
          end
          default: imr <= wdata;
        endcase
      end
    end
  end

endmodule

// File: rtl/pic8_reqs.sv
module pic8_reqs
  import pic8_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr,
  input  logic         flush,
  output logic [N-1:0] irr
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      if (flush) irr <= '0;
      else       irr <= (irr & irq_in & ~clr) | rise;
    end
  end

endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve
  import pic8_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  imr,
  input  logic          aeoi,
  input  logic          ready,
  input  logic [7-LW:0] vec_base,
  input  logic          inta_req,
  input  logic          eoi_spec,
  input  logic [LW-1:0] eoi_idx,
  input  logic          eoi_any,
  input  logic          flush,
  output logic [N-1:0]  isr,
  output logic          int_out,
  output logic          inta_ack,
  output logic [7:0]    vec_out,
  output logic [N-1:0]  irr_clr,
  output logic [N-1:0]  isr_set,
  output logic [N-1:0]  eoi_clr,
  output logic          ack_hit,
  output logic          ack_spur,
  output logic [LW-1:0] ack_idx
);

  localparam logic [LW:0] NONE = (LW+1)'(N);

  logic [LW:0]  isr_top, win;
  logic [N-1:0] cand;

  assign isr_top  = first_set(isr);
  assign cand     = irr & ~imr & below_mask(isr_top);
  assign win      = first_set(cand);
  assign int_out  = ready && (win != NONE);
  assign ack_idx  = win[LW-1:0];
  assign ack_hit  = inta_req && int_out;
  assign ack_spur = inta_req && !int_out;
  assign irr_clr  = ack_hit ? onehot(ack_idx) : '0;
  assign isr_set  = (ack_hit && !aeoi) ? onehot(ack_idx) : '0;

  always_comb begin
    eoi_clr = '0;
    if (eoi_spec) eoi_clr = onehot(eoi_idx);
    else if (eoi_any && isr_top != NONE) eoi_clr = onehot(isr_top[LW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr      <= '0;
      inta_ack <= 1'b0;
      vec_out  <= '0;
    end else begin
      if (flush) isr <= '0;
      else       isr <= (isr & ~eoi_clr) | isr_set;
      inta_ack <= inta_req;
      if (inta_req)
        vec_out <= make_vector(vec_base, ack_hit ? ack_idx : LW'(N - 1));
      else
        vec_out <= '0;
    end
  end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] irq_in,
  output logic          int_out,
  input  logic          inta_req,
  output logic          inta_ack,
  output logic [7:0]    vec_out
);

  logic [DW-1:0] imr_q, irr_q, isr_q, irr_clr, isr_set, eoi_clr;
  logic [7-LW:0] vec_base;
  logic          cfg_aeoi, cfg_ready, rd_isr, init_start;
  logic          eoi_spec, eoi_any, ack_hit, ack_spur;
  logic [LW-1:0] eoi_idx, ack_idx;

  pic8_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
    .imr(imr_q), .vec_base(vec_base), .aeoi(cfg_aeoi), .ready(cfg_ready),
    .rd_isr(rd_isr), .init_start(init_start), .eoi_spec(eoi_spec),
    .eoi_idx(eoi_idx), .eoi_any(eoi_any)
  );

  pic8_reqs #(.N(DW)) u_reqs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(irr_clr),
    .flush(init_start), .irr(irr_q)
  );

  pic8_resolve #(.N(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .irr(irr_q), .imr(imr_q), .aeoi(cfg_aeoi),
    .ready(cfg_ready), .vec_base(vec_base), .inta_req(inta_req),
    .eoi_spec(eoi_spec), .eoi_idx(eoi_idx), .eoi_any(eoi_any),
    .flush(init_start), .isr(isr_q), .int_out(int_out), .inta_ack(inta_ack),
    .vec_out(vec_out), .irr_clr(irr_clr), .isr_set(isr_set),
    .eoi_clr(eoi_clr), .ack_hit(ack_hit), .ack_spur(ack_spur),
    .ack_idx(ack_idx)
  );

  assign bus_rdata = bus_sel ? imr_q : (rd_isr ? isr_q : irr_q);

endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic8_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          inta_req,
  input logic          inta_ack,
  input logic [7:0]    vec_out,
  input logic          int_out,
  input logic          ready,
  input logic          aeoi,
  input logic [7:0]    isr,
  input logic          ack_hit,
  input logic          ack_spur,
  input logic [LW-1:0] ack_idx,
  input logic [7:0]    isr_set,
  input logic [7:0]    eoi_clr,
  input logic          init_start
);

  // R1
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  // R6
  ack_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_req |=> inta_ack);

  // R6
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_ack |-> (vec_out == 8'h00));

  // R6
  isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !aeoi && !init_start) |=>
      ((isr & (8'h01 << $past(ack_idx))) != 8'h00));

  // R7
  aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && aeoi && eoi_clr == 8'h00 && !init_start) |=> $stable(isr));

  // R8
  spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_spur |=> (vec_out[2:0] == 3'd7));

  // R8
  spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && eoi_clr == 8'h00 && !init_start) |=> $stable(isr));

  // R9
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr != 8'h00 && isr_set == 8'h00 && !init_start) |=>
      ((isr & $past(eoi_clr)) == 8'h00));

  // R10
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr != 8'h00) |-> $onehot0(eoi_clr));

endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta_req(inta_req), .inta_ack(inta_ack),
  .vec_out(vec_out), .int_out(int_out), .ready(cfg_ready), .aeoi(cfg_aeoi),
  .isr(isr_q), .ack_hit(ack_hit), .ack_spur(ack_spur), .ack_idx(ack_idx),
  .isr_set(isr_set), .eoi_clr(eoi_clr), .init_start(init_start)
);

// File: tb/pic8_ctrl_test.sv
module pic8_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] irq = 8'h00;
  logic       int_out;
  logic       inta_req = 1'b0;
  logic       inta_ack;
  logic [7:0] vec_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pic8_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq),
    .int_out(int_out), .inta_req(inta_req), .inta_ack(inta_ack),
    .vec_out(vec_out)
  );

  task automatic check_eq(input logic [7:0] act, input logic [7:0] exp,
                          input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = sel;
    #1 check_eq(bus_rdata, exp, tag);
  endtask

  task automatic int_chk(input logic exp, input string tag);
    @(negedge clk);
    #1 check_eq({7'd0, int_out}, {7'd0, exp}, tag);
  endtask

  task automatic set_irq(input int n, input logic v);
    @(negedge clk);
    irq[n] = v;
    @(negedge clk);
  endtask

  // Driver: records the expected vector, then issues the request pulse.
  task automatic do_ack(input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    inta_req = 1'b1;
    @(negedge clk);
    inta_req = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops an expected vector for every acknowledge pulse.
  always @(negedge clk) begin
    if (rst_n && inta_ack) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6: unexpected ack vector 0x%02h expected none", vec_out);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        check_eq(vec_out, e, t);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(1'b1, 8'hFF, "R1 mask after reset");
    rd_chk(1'b0, 8'h00, "R1 pending after reset");
    int_chk(1'b0, "R1 int low after reset");
    wr(1'b1, 8'h00);
    set_irq(0, 1'b1);
    int_chk(1'b0, "R1 int low before configuration");
    set_irq(0, 1'b0);

    // R2 full sequence: base 0x20, cascade word, mode word without auto retire
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd_chk(1'b1, 8'h00, "R2 mask kept through configuration");

    // R3 mask load and read
    wr(1'b1, 8'hF0);
    rd_chk(1'b1, 8'hF0, "R3 mask readback");
    wr(1'b1, 8'h00);

    // R4 R5 R6 first request
    set_irq(3, 1'b1);
    int_chk(1'b1, "R5 int for level 3");
    rd_chk(1'b0, 8'h08, "R4 pending bit 3");
    do_ack(8'h23, "R6 vector level 3");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h08, "R6 in-service bit 3");
    int_chk(1'b0, "R4 pending cleared by ack");
    rd_chk(1'b0, 8'h08, "R11 selection persists");

    // R5 gating by in-service level
    set_irq(5, 1'b1);
    int_chk(1'b0, "R5 level 5 blocked by level 3");
    set_irq(1, 1'b1);
    int_chk(1'b1, "R5 level 1 preempts");
    do_ack(8'h21, "R6 vector level 1");
    rd_chk(1'b0, 8'h0A, "R6 in-service 1 and 3");

    // R10 R9 retirement
    wr(1'b0, 8'h20);
    rd_chk(1'b0, 8'h08, "R10 non-specific clears level 1");
    wr(1'b0, 8'h63);
    rd_chk(1'b0, 8'h00, "R9 specific clears level 3");
    int_chk(1'b1, "R5 level 5 now served");
    do_ack(8'h25, "R6 vector level 5");
    rd_chk(1'b0, 8'h20, "R6 in-service bit 5");
    wr(1'b0, 8'h61);
    rd_chk(1'b0, 8'h20, "R9 other level untouched");
    wr(1'b0, 8'h65);
    rd_chk(1'b0, 8'h00, "R9 level 5 cleared");
    set_irq(1, 1'b0); set_irq(3, 1'b0); set_irq(5, 1'b0);
    wr(1'b0, 8'h0A);
    rd_chk(1'b0, 8'h00, "R11 pending selected again");

    // R3 R4 R8 masked request and spurious acknowledge
    wr(1'b1, 8'h04);
    set_irq(2, 1'b1);
    int_chk(1'b0, "R3 masked level 2 silent");
    rd_chk(1'b0, 8'h04, "R4 pending despite mask");
    do_ack(8'h27, "R8 spurious vector masked");
    rd_chk(1'b0, 8'h04, "R8 pending unchanged");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R8 in-service unchanged");
    set_irq(2, 1'b0);

    // R8 vanished request
    wr(1'b1, 8'h00);
    set_irq(6, 1'b1);
    int_chk(1'b1, "R5 level 6 raised");
    set_irq(6, 1'b0);
    int_chk(1'b0, "R4 pending dropped with input");
    do_ack(8'h27, "R8 spurious vector vanished");
    rd_chk(1'b0, 8'h00, "R8 no in-service after vanish");

    // R2 R7 reconfigure with automatic retirement, base 0x40
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    set_irq(4, 1'b1);
    rd_chk(1'b0, 8'h10, "R2 readback back to pending");
    do_ack(8'h44, "R7 vector level 4");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R7 in-service stays clear");
    set_irq(4, 1'b0);

    // R2 short sequence: single, no mode word, base 0x80
    wr(1'b0, 8'h12); wr(1'b1, 8'h80);
    wr(1'b1, 8'h00);
    rd_chk(1'b1, 8'h00, "R2 next data write is mask");
    set_irq(0, 1'b1);
    do_ack(8'h80, "R2 vector level 0 base 0x80");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h01, "R2 auto retire off without mode word");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R6: actual %0d vectors missing expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule